// File: doc/BRIEF.md
# Burst Data-Transfer Target for a Shared Address/Data Bus

This block is the responding side of a synchronous bus where address and data share one set of lines, and where the framing, ready and select controls are active low. An initiator starts a transaction by pulling the frame line low for one cycle. In that cycle it also presents a byte address and a four-bit command. The target decodes that address phase. If the address falls inside its 64-word window and the command is a read or a write, the target claims the transaction. It then moves words between the bus and a local register memory, one word per edge on which both sides report ready. Bursts have no fixed length.

Each burst starts with a programmable number of wait states. On reads, the target leaves one idle turnaround cycle on the shared lines before it drives them. The initiator marks its final data phase by releasing the frame line. If a burst would run past the last word of the window, the target disconnects it with a stop indication. Because this is a plain-port model of a shared bus, each line the target drives comes with an output enable.

Top module: `burstTarget`

## Requirements
- R1: After reset, devselN, trdyN and stopN are high, ctlOe and adOe are low, and every word of the local memory reads as zero.
- R2: The target claims a transaction only on the first cycle in which frameN is low after a cycle in which it was high. Three conditions must all hold: the command on cbeN is read (0110) or write (0111); address bits [31:8] equal those of BASE_ADDR; and bits [1:0] are 00. Bits [7:2] select the word. A claim drives devselN low on the next edge. Any other address phase leaves devselN, trdyN and stopN high and leaves the memory unchanged.
- R3: When the address phase is counted as edge 0, trdyN is first asserted on edge 1+W. Here W is the value on cfgWait sampled at the address phase.
- R4: On a read, adOe stays low in the cycle after the address phase (the turnaround cycle). It goes high from edge 1 onward, while the burst is still active.
- R5: A data word moves only on an edge where irdyN and trdyN are both low. On a write, that edge stores adIn into the addressed word. On a read, adOut carries the addressed word during that cycle.
- R6: Each completed data phase advances the word index by one. A burst that starts at word 0 and runs for 64 phases visits every word in order.
- R7: An edge that completes a transfer while frameN is high ends the burst. In the next cycle devselN and trdyN are high, adOe is low and ctlOe is still high. One cycle later ctlOe is low.
- R8: A transfer at word 63 while frameN is still low makes the target drive stopN low and trdyN high, with no further transfer. Once frameN is sampled high, stopN and devselN return high, and ctlOe falls one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| frameN | input | 1 | Initiator framing, active low |
| irdyN | input | 1 | Initiator ready, active low |
| cbeN | input | 4 | Command during the address phase |
| adIn | input | DATAW | Shared lines as seen by the target |
| cfgWait | input | WAITW | Wait states at the start of each burst |
| adOut | output | DATAW | Read data driven onto the shared lines |
| adOe | output | 1 | Output enable for adOut |
| devselN | output | 1 | Target claims the transaction, active low |
| trdyN | output | 1 | Target ready, active low |
| stopN | output | 1 | Target disconnect request, active low |
| ctlOe | output | 1 | Output enable for devselN, trdyN, stopN |

## Verification
The hardest case to reach is the window-end disconnect, and in particular the path where the initiator still has phases left when the target stops it. The stimulus reaches this case in two ways. Directed bursts start near word 63 with lengths past the edge. Random bursts pick start words and lengths independently, so some of them cross the boundary. In both cases the bench model counts the phases completed before the stop and checks that no word beyond the window is touched. Random initiator wait cycles are spread across bursts so that both ready-edge orders occur, and the final phase sometimes follows an idle initiator cycle.

// File: rtl/bt_pkg.sv
package bt_pkg;
  localparam logic [3:0] CMD_READ  = 4'b0110;
  localparam logic [3:0] CMD_WRITE = 4'b0111;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_DATA,
    ST_STOP,
    ST_TURN
  } btState_e;

  typedef struct packed {
    logic loadAddr;
    logic incAddr;
    logic writeEn;
  } btStrobe_t;
endpackage

// File: rtl/btDatapath.sv
module btDatapath
  import bt_pkg::*;
#(
  parameter int DATAW = 32,
  parameter int IDXW = 6,
  parameter logic [DATAW-1:0] BASE_ADDR = 32'h0000_1000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DATAW-1:0] adIn,
  input  btStrobe_t        strobe,
  output logic             hit,
  output logic             lastWord,
  output logic [DATAW-1:0] rdData
);
  localparam int DEPTH  = 1 << IDXW;
  localparam int OFFW   = $clog2(DATAW / 8);
  localparam int ADDRLO = IDXW + OFFW;

  logic [IDXW-1:0]  wordIdx;
  logic [DATAW-1:0] mem [DEPTH];

  // claim needs the upper bits to match and linear burst order in the low bits
  assign hit = (adIn[DATAW-1:ADDRLO] == BASE_ADDR[DATAW-1:ADDRLO]) &&
               (adIn[OFFW-1:0] == '0);
  assign lastWord = (wordIdx == IDXW'(DEPTH - 1));
  assign rdData = mem[wordIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordIdx <= '0;
    end else if (strobe.loadAddr) begin
      wordIdx <= adIn[ADDRLO-1:OFFW];
    end else if (strobe.incAddr) begin
      wordIdx <= wordIdx + IDXW'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (strobe.writeEn) begin
      mem[wordIdx] <= adIn;
    end
  end

  // R6: every completed phase steps the word index by exactly one
  p_index_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.incAddr && !strobe.loadAddr) |=> (wordIdx == $past(wordIdx) + IDXW'(1)));

  // R5: a store never coincides with a new address phase
  p_write_not_on_claim_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.writeEn && strobe.loadAddr));
endmodule

// File: rtl/btControl.sv
module btControl
  import bt_pkg::*;
#(
  parameter int WAITW = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameN,
  input  logic             irdyN,
  input  logic [3:0]       cbeN,
  input  logic [WAITW-1:0] cfgWait,
  input  logic             hit,
  input  logic             lastWord,
  output btStrobe_t        strobe,
  output logic             devselN,
  output logic             trdyN,
  output logic             stopN,
  output logic             ctlOe,
  output logic             adOe
);
  btState_e         state;
  logic             frameQ;
  logic             isRead;
  logic [WAITW-1:0] waitCnt;
  logic             frameStart;
  logic             cmdOk;
  logic             claim;
  logic             xfer;

  assign frameStart = frameQ && !frameN;
  assign cmdOk      = (cbeN == CMD_READ) || (cbeN == CMD_WRITE);
  assign claim      = (state == ST_IDLE) && frameStart && cmdOk && hit;
  assign xfer       = (state == ST_DATA) && !irdyN;

  always_comb begin
    strobe          = '0;
    strobe.loadAddr = claim;
    strobe.incAddr  = xfer;
    strobe.writeEn  = xfer && !isRead;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) frameQ <= 1'b1;
    else       frameQ <= frameN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      isRead  <= 1'b0;
      waitCnt <= '0;
      devselN <= 1'b1;
      trdyN   <= 1'b1;
      stopN   <= 1'b1;
      ctlOe   <= 1'b0;
      adOe    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          ctlOe <= 1'b0;
          if (claim) begin
            state   <= ST_WAIT;
            isRead  <= (cbeN == CMD_READ);
            waitCnt <= cfgWait;
            devselN <= 1'b0;
            ctlOe   <= 1'b1;
          end
        end
        ST_WAIT: begin
          // the cycle just ended was the turnaround; reads may drive from now on
          if (isRead) adOe <= 1'b1;
          if (waitCnt == '0) begin
            trdyN <= 1'b0;
            state <= ST_DATA;
          end else begin
            waitCnt <= waitCnt - WAITW'(1);
          end
        end
        ST_DATA: begin
          if (xfer) begin
            if (frameN) begin
              state   <= ST_TURN;
              devselN <= 1'b1;
              trdyN   <= 1'b1;
              adOe    <= 1'b0;
            end else if (lastWord) begin
              state <= ST_STOP;
              trdyN <= 1'b1;
              stopN <= 1'b0;
              adOe  <= 1'b0;
            end
          end
        end
        ST_STOP: begin
          if (frameN) begin
            state   <= ST_TURN;
            devselN <= 1'b1;
            stopN   <= 1'b1;
          end
        end
        ST_TURN: begin
          state <= ST_IDLE;
          ctlOe <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: a claimed address phase selects the device on the next edge
  p_select_after_claim_r2: assert property (@(posedge clk) disable iff (!rstN)
    claim |=> !devselN);

  // R4: a read leaves the shared lines idle during the turnaround cycle
  p_read_turnaround_r4: assert property (@(posedge clk) disable iff (!rstN)
    (claim && cbeN == CMD_READ) |=> !adOe);

  // R5: target ready is only shown while the device is selected
  p_ready_needs_select_r5: assert property (@(posedge clk) disable iff (!rstN)
    !trdyN |-> (!devselN && ctlOe));

  // R7: the final phase releases select, ready and the data drivers
  p_final_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    (xfer && frameN) |=> (devselN && trdyN && !adOe && ctlOe));

  // R8: stop and ready are never shown together
  p_stop_excludes_ready_r8: assert property (@(posedge clk) disable iff (!rstN)
    !stopN |-> trdyN);

  // R8: a transfer at the last word with more phases pending raises stop
  p_window_stop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (xfer && !frameN && lastWord) |=> !stopN);
endmodule

// File: rtl/burstTarget.sv
module burstTarget
  import bt_pkg::*;
#(
  parameter int DATAW = 32,
  parameter int IDXW = 6,
  parameter int WAITW = 4,
  parameter logic [DATAW-1:0] BASE_ADDR = 32'h0000_1000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameN,
  input  logic             irdyN,
  input  logic [3:0]       cbeN,
  input  logic [DATAW-1:0] adIn,
  input  logic [WAITW-1:0] cfgWait,
  output logic [DATAW-1:0] adOut,
  output logic             adOe,
  output logic             devselN,
  output logic             trdyN,
  output logic             stopN,
  output logic             ctlOe
);
  btStrobe_t        strobe;
  logic             hit;
  logic             lastWord;
  logic [DATAW-1:0] rdData;

  btControl #(.WAITW(WAITW)) uControl (
    .clk      (clk),
    .rstN     (rstN),
    .frameN   (frameN),
    .irdyN    (irdyN),
    .cbeN     (cbeN),
    .cfgWait  (cfgWait),
    .hit      (hit),
    .lastWord (lastWord),
    .strobe   (strobe),
    .devselN  (devselN),
    .trdyN    (trdyN),
    .stopN    (stopN),
    .ctlOe    (ctlOe),
    .adOe     (adOe)
  );

  btDatapath #(.DATAW(DATAW), .IDXW(IDXW), .BASE_ADDR(BASE_ADDR)) uDatapath (
    .clk      (clk),
    .rstN     (rstN),
    .adIn     (adIn),
    .strobe   (strobe),
    .hit      (hit),
    .lastWord (lastWord),
    .rdData   (rdData)
  );

  assign adOut = adOe ? rdData : '0;
endmodule

// File: tb/burstTarget_test.sv
module burstTarget_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h0000_1000;
  localparam logic [3:0] RD = 4'b0110;
  localparam logic [3:0] WR = 4'b0111;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameN = 1'b1;
  logic        irdyN = 1'b1;
  logic [3:0]  cbeN = 4'h0;
  logic [31:0] adIn = '0;
  logic [3:0]  cfgWait = 4'd0;
  logic [31:0] adOut;
  logic        adOe, devselN, trdyN, stopN, ctlOe;

  int checks = 0;
  int fails = 0;
  bit summaryDone = 1'b0;
  logic [31:0] model [64];

  burstTarget uut (
    .clk(clk), .rstN(rstN), .frameN(frameN), .irdyN(irdyN), .cbeN(cbeN),
    .adIn(adIn), .cfgWait(cfgWait), .adOut(adOut), .adOe(adOe),
    .devselN(devselN), .trdyN(trdyN), .stopN(stopN), .ctlOe(ctlOe)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int expectedPhases(input int startIdx, input int len);
    return (len <= 64 - startIdx) ? len : 64 - startIdx;
  endfunction

  task automatic finishRun();
    if (!summaryDone) begin
      summaryDone = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    end
    $finish;
  endtask

  // behavioural initiator: one burst, gapPct = chance of an idle initiator cycle
  task automatic runBurst(input int startIdx, input logic [31:0] addrOverride,
                          input bit useOverride, input logic [3:0] cmd,
                          input int len, input int gapPct, input bit expHit);
    int k, nx, firstK, idx, expN;
    bit lastPh, done, stopped, isRd;
    logic [31:0] wdata;
    isRd = (cmd == RD);
    idx = startIdx;
    expN = expectedPhases(startIdx, len);
    @(negedge clk);
    frameN = 1'b0; irdyN = 1'b1; cbeN = cmd;
    adIn = useOverride ? addrOverride : (BASE | (32'(startIdx) << 2));
    @(negedge clk);
    k = 1;
    cbeN = 4'h0; adIn = '0;
    check(devselN == !expHit, "R2 select", {31'd0, devselN}, {31'd0, !expHit});
    if (!expHit) begin
      frameN = 1'b1;
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        check(devselN && trdyN && stopN, "R2 ignored phase",
              {29'd0, devselN, trdyN, stopN}, 32'h7);
      end
      return;
    end
    if (isRd) check(adOe == 1'b0, "R4 turnaround idle", {31'd0, adOe}, 32'd0);
    lastPh = 0; done = 0; stopped = 0; nx = 0; firstK = 0;
    wdata = $urandom;
    while (!done) begin
      if (k == 2 && isRd) check(adOe == 1'b1, "R4 drive after turnaround", {31'd0, adOe}, 32'd1);
      if (!stopN) begin
        check(nx == expN && len > expN, "R8 phases before stop", 32'(nx), 32'(expN));
        check(trdyN == 1'b1, "R8 ready off with stop", {31'd0, trdyN}, 32'd1);
        frameN = 1'b1; irdyN = 1'b0;
        stopped = 1; done = 1;
      end else begin
        if (!trdyN && firstK == 0) begin
          firstK = k;
          check(k == 32'(cfgWait) + 2, "R3 wait states", 32'(k), 32'(cfgWait) + 2);
        end
        if (lastPh || ($urandom_range(99) >= gapPct)) begin
          irdyN = 1'b0;
          if (len - nx == 1) begin lastPh = 1; frameN = 1'b1; end
        end else begin
          irdyN = 1'b1;
        end
        adIn = isRd ? 32'd0 : wdata;
        if (!irdyN && !trdyN) begin
          if (isRd) check(adOut == model[idx], "R5 R6 read word", adOut, model[idx]);
          else model[idx] = wdata;
          idx++; nx++;
          wdata = $urandom;
          if (lastPh) done = 1;
        end
      end
      @(negedge clk);
      k++;
      if (k > 400) begin
        check(1'b0, "R5 burst progress", 32'(k), 32'd400);
        done = 1;
      end
    end
    if (stopped) begin
      check(stopN && devselN, "R8 stop release", {30'd0, stopN, devselN}, 32'h3);
      irdyN = 1'b1;
      @(negedge clk);
      check(ctlOe == 1'b0, "R8 drivers off", {31'd0, ctlOe}, 32'd0);
    end else begin
      check(nx == len, "R7 phase count", 32'(nx), 32'(len));
      check(devselN && trdyN && !adOe && ctlOe, "R7 end of burst",
            {28'd0, devselN, trdyN, adOe, ctlOe}, 32'hD);
      irdyN = 1'b1; frameN = 1'b1;
      @(negedge clk);
      check(ctlOe == 1'b0, "R7 drivers off", {31'd0, ctlOe}, 32'd0);
    end
    adIn = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 32'd0, 32'd1);
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    check(devselN && trdyN && stopN && !ctlOe && !adOe, "R1 reset outputs",
          {27'd0, devselN, trdyN, stopN, ctlOe, adOe}, 32'h1C);
    rstN = 1'b1;
    @(negedge clk);
    // R1 and R6: whole window reads zero in order
    cfgWait = 4'd0;
    runBurst(0, '0, 0, RD, 64, 0, 1);
    // R6: fill and read back the whole window with initiator gaps
    runBurst(0, '0, 0, WR, 64, 20, 1);
    cfgWait = 4'd2;
    runBurst(0, '0, 0, RD, 64, 35, 1);
    // R8: bursts that run past the window end
    cfgWait = 4'd1;
    runBurst(60, '0, 0, WR, 8, 0, 1);
    runBurst(62, '0, 0, RD, 5, 25, 1);
    // R7: single-phase bursts, one ending exactly at word 63
    runBurst(63, '0, 0, WR, 1, 0, 1);
    runBurst(63, '0, 0, RD, 1, 0, 1);
    // R3: long wait count
    cfgWait = 4'd9;
    runBurst(5, '0, 0, RD, 3, 0, 1);
    // R2: out-of-window, misaligned and unsupported commands are ignored
    cfgWait = 4'd0;
    runBurst(0, 32'h0000_2004, 1, WR, 4, 0, 0);
    runBurst(0, BASE | 32'h0000_0012, 1, WR, 4, 0, 0);
    runBurst(4, '0, 0, 4'b0011, 4, 0, 0);
    runBurst(4, '0, 0, 4'b0010, 4, 0, 0);
    // random mix
    for (int n = 0; n < 40; n++) begin
      cfgWait = 4'($urandom_range(3));
      runBurst(int'($urandom_range(63)), '0, 0, ($urandom_range(1) == 0) ? RD : WR,
               int'($urandom_range(1, 10)), int'($urandom_range(40)), 1);
    end
    // final sweep proves ignored phases left memory intact (R2)
    cfgWait = 4'd1;
    runBurst(0, '0, 0, RD, 64, 30, 1);
    finishRun();
  end
endmodule